// File: doc/BRIEF.md
# Banked Word-Addressed SRAM

This block is a synchronous memory of 32-bit words that is split into independent banks. The row of each bank holds several words side by side. A request has an address, a write data word and separate read and write strobes. The block captures the request in input registers on a rising clock edge. The address is then split into a bank field, a row field and a column field. Only the addressed bank is enabled, and only that bank touches its array. All other banks stay idle.

Each bank keeps its read result in its own output register. All bank output registers feed one shared read bus through a one-hot selector. The selector remembers which bank completed the most recent read, so the bus keeps showing that word until another read finishes. The full-size configuration uses 5 bank bits, 7 row bits and 3 column bits: 32 banks of 128 rows, each row 256 bits, 1 Mbit in total. The parameter defaults give a reduced size for simulation.

The strobes are plain control pins. There is no valid/ready handshake. The block accepts a request on every clock, and a read always completes after a fixed number of edges, so it never exerts back-pressure.

Top module: `banked_word_sram`

## Requirements
- R1: The address splits, from most to least significant, into a bank field of BANK_AW bits, a row field of ROW_AW bits and a column field of COL_AW bits. Address value a therefore names word slot a[COL_AW-1:0] of row a[COL_AW+ROW_AW-1:COL_AW] in bank a[AW-1:COL_AW+ROW_AW].
- R2: A read presented before rising edge k is captured at edge k and reaches rd_data after edge k+1. Between those two edges, rd_data still shows the previous result.
- R3: A write replaces only the one word slot that the column field names. The other word slots of that row keep their contents.
- R4: On a read, the column field picks one word out of the addressed row.
- R5: Banks are independent. A write to one bank leaves the same row and column of every other bank unchanged.
- R6: When rd_en and wr_en are both high, the write is performed and the read is dropped. rd_data keeps its previous value.
- R7: rd_data holds the last read word through idle cycles and through write-only cycles.
- R8: Synchronous reset clears the input registers and every bank output register, so rd_data reads zero after reset. Array contents are not cleared.
- R9: At most one bank is enabled in any cycle, and no bank is enabled when no request was captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, wins over rd_en |
| addr | input | BANK_AW+ROW_AW+COL_AW | Word address (bank, row, column) |
| wr_data | input | DW | Word to write |
| rd_data | output | DW | Shared read bus, last completed read |

## Verification
The bench first writes every word of the reduced configuration with a pattern that is distinct for each address, then reads every word back. A design that swaps or overlaps the address fields returns another word's pattern. Column-slot overwrites and writes to the same row in other banks check that a write does not spill into neighbouring slots or other banks. Simultaneous read and write requests, idle gaps and a mid-run reset check that the bus neither picks up a stale bank, nor updates on a dropped read, nor keeps data across reset. The bench also samples rd_data between the two edges of a read, which catches a design that runs one cycle early or late.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  // Decoded access kind after the input registers; write has priority.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bsram_req_stage.sv
module bsram_req_stage
  import bsram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output op_e           op_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);
  op_e op_d;

  always_comb begin
    if (wr_en)      op_d = OP_WRITE;
    else if (rd_en) op_d = OP_READ;
    else            op_d = OP_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      op_q    <= op_d;
      addr_q  <= addr;
      wdata_q <= wr_data;
    end
  end
endmodule

// File: rtl/bsram_bank.sv
module bsram_bank
  import bsram_pkg::*;
#(
  parameter int ROW_AW = 3,
  parameter int COL_AW = 3,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  op_e               op,
  input  logic [ROW_AW-1:0] row,
  input  logic [COL_AW-1:0] col,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     out_q
);
  localparam int ROWS  = 1 << ROW_AW;
  localparam int SLOTS = 1 << COL_AW;
  localparam int ROW_W = SLOTS * DW;

  logic [ROW_W-1:0] arr [ROWS];
  logic [ROW_W-1:0] row_word;

  assign row_word = arr[row];

  // Only the named word slot of the row is replaced.
  always_ff @(posedge clk) begin
    if (en && op == OP_WRITE)
      arr[row][col*DW +: DW] <= wdata;
  end

  // Column select on read: one word out of the row.
  always_ff @(posedge clk) begin
    if (rst)
      out_q <= '0;
    else if (en && op == OP_READ)
      out_q <= row_word[col*DW +: DW];
  end

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(out_q));

  assert_write_no_read_R6: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_WRITE) |=> $stable(out_q));
endmodule

// File: rtl/bsram_out_mux.sv
module bsram_out_mux #(
  parameter int N  = 4,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         sel,
  input  logic [N-1:0][DW-1:0] din,
  output logic [DW-1:0]        dout
);
  // One-hot AND-OR selection standing in for a shared tri-state bus.
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++)
      dout = dout | (din[i] & {DW{sel[i]}});
  end

  assert_single_driver_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
endmodule

// File: rtl/banked_word_sram.sv
module banked_word_sram
  import bsram_pkg::*;
#(
  parameter int BANK_AW = 2,
  parameter int ROW_AW  = 3,
  parameter int COL_AW  = 3,
  parameter int DW      = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_en,
  input  logic                          wr_en,
  input  logic [BANK_AW+ROW_AW+COL_AW-1:0] addr,
  input  logic [DW-1:0]                 wr_data,
  output logic [DW-1:0]                 rd_data
);
  localparam int AW    = BANK_AW + ROW_AW + COL_AW;
  localparam int NBANK = 1 << BANK_AW;

  op_e                      op_q;
  logic [AW-1:0]            addr_q;
  logic [DW-1:0]            wdata_q;
  logic [BANK_AW-1:0]       bank_idx;
  logic [ROW_AW-1:0]        row_idx;
  logic [COL_AW-1:0]        col_idx;
  logic [NBANK-1:0]         bank_en;
  logic [NBANK-1:0]         out_sel_q;
  logic [NBANK-1:0][DW-1:0] bank_out;

  bsram_req_stage #(.AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data),
    .op_q(op_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  assign bank_idx = addr_q[AW-1 -: BANK_AW];
  assign row_idx  = addr_q[COL_AW +: ROW_AW];
  assign col_idx  = addr_q[COL_AW-1:0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_en[b] = (op_q != OP_IDLE) && (bank_idx == BANK_AW'(b));

    bsram_bank #(.ROW_AW(ROW_AW), .COL_AW(COL_AW), .DW(DW)) u_bank (
      .clk(clk), .rst(rst), .en(bank_en[b]), .op(op_q),
      .row(row_idx), .col(col_idx), .wdata(wdata_q),
      .out_q(bank_out[b])
    );
  end

  // Remember which bank finished the latest read; it keeps the bus.
  always_ff @(posedge clk) begin
    if (rst)
      out_sel_q <= '0;
    else if (op_q == OP_READ)
      out_sel_q <= bank_en;
  end

  bsram_out_mux #(.N(NBANK), .DW(DW)) u_mux (
    .clk(clk), .rst(rst), .sel(out_sel_q), .din(bank_out), .dout(rd_data)
  );

  assert_one_bank_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_en));

  assert_idle_no_bank_R9: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_IDLE) |-> (bank_en == '0));

  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0));
endmodule

// File: tb/sim_banked_word_sram.sv
`timescale 1ns/1ps
module sim_banked_word_sram;
  localparam int BANK_AW = 2;
  localparam int ROW_AW  = 3;
  localparam int COL_AW  = 3;
  localparam int DW      = 32;
  localparam int AW      = BANK_AW + ROW_AW + COL_AW;
  localparam int NW      = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] model [NW];

  always #4 clk = ~clk;

  banked_word_sram #(.BANK_AW(BANK_AW), .ROW_AW(ROW_AW), .COL_AW(COL_AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'((a + 1) * 32'h9E37_79B1) ^ DW'(salt * 32'h0101_0F0F);
  endfunction

  function automatic int mk(int b, int r, int c);
    return (b << (ROW_AW + COL_AW)) | (r << COL_AW) | c;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic r, logic w, int a, logic [DW-1:0] d);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = AW'(a); wr_data = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    if (w) model[a] = d;
  endtask

  task automatic rd_chk(string req, int a);
    issue(1'b1, 1'b0, a, '0);
    @(negedge clk);
    chk(req, rd_data, model[a]);
  endtask

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    chk("R8 reset", rd_data, '0);
    rst = 1'b0;

    // Full sweep: write every word, read every word back (R1, R4).
    for (int a = 0; a < NW; a++) issue(1'b0, 1'b1, a, pat(a, 0));
    for (int a = 0; a < NW; a++) rd_chk("R1/R4 sweep", a);

    // R3: overwrite one slot, the rest of the row is intact.
    issue(1'b0, 1'b1, mk(1, 2, 3), 32'hDEAD_BEEF);
    for (int c = 0; c < (1 << COL_AW); c++) rd_chk("R3 slot", mk(1, 2, c));

    // R5: the same row/column in every other bank is unchanged.
    for (int b = 0; b < (1 << BANK_AW); b++) rd_chk("R5 bank", mk(b, 2, 3));

    // R2: latency, previous value visible between the two edges.
    rd_chk("R2 prior", mk(2, 5, 1));
    held = rd_data;
    issue(1'b1, 1'b0, mk(3, 6, 7), '0);
    chk("R2 one edge", rd_data, held);
    @(negedge clk);
    chk("R2 two edges", rd_data, model[mk(3, 6, 7)]);

    // R6: read and write together, write wins, bus unchanged.
    held = rd_data;
    issue(1'b1, 1'b1, mk(0, 4, 2), 32'h1234_5678);
    @(negedge clk);
    chk("R6 bus held", rd_data, held);
    rd_chk("R6 write done", mk(0, 4, 2));

    // R7: idle cycles and writes to other banks leave the bus alone.
    held = rd_data;
    repeat (4) @(negedge clk);
    chk("R7 idle", rd_data, held);
    issue(1'b0, 1'b1, mk(2, 1, 0), 32'hCAFE_0001);
    issue(1'b0, 1'b1, mk(0, 4, 5), 32'hCAFE_0002);
    @(negedge clk);
    chk("R7 after writes", rd_data, held);
    rd_chk("R7 readback", mk(2, 1, 0));

    // R8: reset mid-run clears the bus but not the array.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R8 mid-run", rd_data, '0);
    rd_chk("R8 array kept", mk(0, 4, 5));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule